// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns one request into the command and address phases of a small-page NAND flash bus. A request carries an opcode, a column offset, a page number and two flags that mark the column or the page as absent. The block drives the command-latch strobe while it sends command bytes. It then drives the address-latch strobe while it sends the column byte and the page bytes. Each byte is written with a write-enable low pulse. After the last byte the block waits a programmable settle time and then pulses `done`.

A sequential-input (program setup, opcode 0x80) request needs extra work, because the column can point into the first half, the second half or the spare area of a page. The block first sends a pointer command that selects that region. It then sends 0x80 and a column rebased to the start of the region. Two configuration inputs set the page geometry (256- or 512-byte pages) and whether a third page-address byte is needed for high-density parts. The block does not transfer data, poll ready/busy, compute ECC or control chip enable.

Top module: `nand_cmd_seq`

## Requirements
- R1: CLE is high for every command byte and ALE is high for every address byte. The two are never high together. Both are low while idle, while settling and when `done` is high.
- R2: For any opcode other than 0x80, the command phase is exactly that one opcode byte.
- R3: For opcode 0x80 on a 512-byte-page part (`big_page`=1), the pointer command depends on the column. A column below 256 gets 0x00 and is sent unchanged. A column from 256 to 511 gets 0x01 and is sent minus 256. A column of 512 or more gets 0x50 and is sent minus 512. Each pointer byte is followed by 0x80. An absent column counts as 0.
- R4: For opcode 0x80 on a 256-byte-page part (`big_page`=0), a column of 256 or more gives the commands 0xFF, 0x50, 0x80 and a column sent minus 256. A smaller column gives the commands 0x00, 0x80.
- R5: The address bytes come in this order: the column's low 8 bits, page[7:0], page[15:8]. The column byte is left out when `req_col_none`=1. All page bytes are left out when `req_page_none`=1.
- R6: When `high_density`=1 and a page is supplied, a third page byte {4'b0, page[19:16]} follows page[15:8].
- R7: Each byte is set up for SETUP_CLKS cycles with WE# high. WE# is then low for PULSE_CLKS cycles and high again for HOLD_CLKS cycles. IO and CLE stay stable while WE# is low.
- R8: `done` is high for one cycle. It arrives N·(SETUP_CLKS+PULSE_CLKS+HOLD_CLKS) + max(settle,1) clocks after the accepting edge, where N is the byte count and settle is the `settle_cycles` value latched at acceptance.
- R9: `req_ready` is high only when idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Requests presented while busy are ignored and send no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken |
| req_opcode | input | 8 | Command opcode |
| req_col | input | COL_W | Column offset |
| req_col_none | input | 1 | Column absent |
| req_page | input | PAGE_W | Page number |
| req_page_none | input | 1 | Page absent |
| big_page | input | 1 | 1: 512-byte pages, 0: 256-byte pages |
| high_density | input | 1 | Adds the third page byte |
| settle_cycles | input | SETTLE_W | Settle wait in clocks, latched on acceptance |
| nand_cle | output | 1 | Command-latch enable |
| nand_ale | output | 1 | Address-latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_io | output | 8 | Bus byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each bus byte is due at a falling WE# edge. The monitor samples on the falling clock edge and compares the byte against a queue in issue order, along with the CLE/ALE levels. It also checks that each low run of WE# lasts PULSE_CLKS cycles. `done` is due N·(SETUP+PULSE+HOLD)+max(settle,1) rising edges after the accepting edge. The driver counts rising edges and samples `done` at each falling edge that follows one, so the count is exact. At `done` the expected queue must be empty, and one falling edge later `done` must be low again.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_SETTLE} seq_state_t;
  typedef enum logic [1:0] {PH_SETUP, PH_LOW, PH_HOLD} strobe_phase_t;

  localparam logic [7:0] OP_SEQ_IN    = 8'h80;
  localparam logic [7:0] OP_PTR_FIRST = 8'h00;
  localparam logic [7:0] OP_PTR_SECND = 8'h01;
  localparam logic [7:0] OP_PTR_SPARE = 8'h50;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam int         MAX_BYTES    = 7;
endpackage

// File: rtl/nand_we_strobe.sv
module nand_we_strobe
  import nand_seq_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic we_n,
  output logic step
);
  localparam int MAX_A = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
  localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
  localparam int CNT_W = $clog2(MAX_C + 1);

  strobe_phase_t phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    case (phase_q)
      PH_SETUP: limit = CNT_W'(SETUP_CLKS);
      PH_LOW:   limit = CNT_W'(PULSE_CLKS);
      default:  limit = CNT_W'(HOLD_CLKS);
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    step    = 1'b0;
    if (!go) begin
      phase_d = PH_SETUP;
      cnt_d   = '0;
    end else if (cnt_q == limit - 1'b1) begin
      cnt_d = '0;
      case (phase_q)
        PH_SETUP: phase_d = PH_LOW;
        PH_LOW:   phase_d = PH_HOLD;
        default: begin
          phase_d = PH_SETUP;
          step    = 1'b1;
        end
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETUP;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign we_n = !(go && phase_q == PH_LOW);

  AST_STEP_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> we_n); // R7
  AST_STEP_THEN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && go) |=> we_n); // R7
endmodule

// File: rtl/nand_seq_plan.sv
module nand_seq_plan
  import nand_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int PAGE_W = 20
) (
  input  logic [7:0]        opcode,
  input  logic [COL_W-1:0]  col,
  input  logic              col_none,
  input  logic [PAGE_W-1:0] page,
  input  logic              page_none,
  input  logic              big_page,
  input  logic              high_density,
  input  logic [2:0]        sel,
  output logic [2:0]        total,
  output logic [7:0]        sel_byte,
  output logic              sel_is_cmd
);
  localparam int PG_PAD = (PAGE_W > 24) ? PAGE_W : 24;

  logic [7:0]        seq_b [MAX_BYTES];
  logic              seq_c [MAX_BYTES];
  logic [2:0]        n;
  logic [COL_W-1:0]  col_eff, col_adj;
  logic [PG_PAD-1:0] pg;

  assign pg      = PG_PAD'(page);
  assign col_eff = col_none ? '0 : col;

  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++) begin
      seq_b[i] = '0;
      seq_c[i] = 1'b0;
    end
    n       = '0;
    col_adj = col_eff;
    if (opcode != OP_SEQ_IN) begin
      seq_b[n] = opcode; seq_c[n] = 1'b1; n = n + 1'b1;
    end else begin
      if (big_page) begin
        if (col_eff < COL_W'(256)) begin
          seq_b[n] = OP_PTR_FIRST;
        end else if (col_eff < COL_W'(512)) begin
          seq_b[n] = OP_PTR_SECND; col_adj = col_eff - COL_W'(256);
        end else begin
          seq_b[n] = OP_PTR_SPARE; col_adj = col_eff - COL_W'(512);
        end
        seq_c[n] = 1'b1; n = n + 1'b1;
      end else if (col_eff >= COL_W'(256)) begin
        seq_b[n] = OP_RESET;     seq_c[n] = 1'b1; n = n + 1'b1;
        seq_b[n] = OP_PTR_SPARE; seq_c[n] = 1'b1; n = n + 1'b1;
        col_adj = col_eff - COL_W'(256);
      end else begin
        seq_b[n] = OP_PTR_FIRST; seq_c[n] = 1'b1; n = n + 1'b1;
      end
      seq_b[n] = OP_SEQ_IN; seq_c[n] = 1'b1; n = n + 1'b1;
    end
    if (!col_none) begin
      seq_b[n] = col_adj[7:0]; n = n + 1'b1;
    end
    if (!page_none) begin
      seq_b[n] = pg[7:0];  n = n + 1'b1;
      seq_b[n] = pg[15:8]; n = n + 1'b1;
      if (high_density) begin
        seq_b[n] = {4'b0000, pg[19:16]}; n = n + 1'b1;
      end
    end
    total = n;
  end

  assign sel_byte   = seq_b[sel];
  assign sel_is_cmd = seq_c[sel];
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int PAGE_W     = 20,
  parameter int SETTLE_W   = 16,
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [7:0]          req_opcode,
  input  logic [COL_W-1:0]    req_col,
  input  logic                req_col_none,
  input  logic [PAGE_W-1:0]   req_page,
  input  logic                req_page_none,
  input  logic                big_page,
  input  logic                high_density,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                nand_cle,
  output logic                nand_ale,
  output logic                nand_we_n,
  output logic [7:0]          nand_io,
  output logic                done
);
  seq_state_t state_q, state_d;
  logic [2:0]          idx_q, idx_d, total;
  logic [SETTLE_W-1:0] wait_q, wait_d, lim_q;
  logic [7:0]          op_q;
  logic [COL_W-1:0]    col_q;
  logic [PAGE_W-1:0]   page_q;
  logic                coln_q, pagen_q, big_q, hd_q, done_q, done_d;
  logic                accept, sending, step, cur_cmd;
  logic [7:0]          cur_byte;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign sending   = (state_q == ST_SEND);

  nand_seq_plan #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_plan (
    .opcode(op_q), .col(col_q), .col_none(coln_q), .page(page_q),
    .page_none(pagen_q), .big_page(big_q), .high_density(hd_q),
    .sel(idx_q), .total(total), .sel_byte(cur_byte), .sel_is_cmd(cur_cmd)
  );

  nand_we_strobe #(.SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS),
                   .HOLD_CLKS(HOLD_CLKS)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(sending), .we_n(nand_we_n), .step(step)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wait_d  = wait_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SEND;
        idx_d   = '0;
      end
      ST_SEND: if (step) begin
        if (idx_q == total - 1'b1) begin
          state_d = ST_SETTLE;
          wait_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: begin
        if (({1'b0, wait_q} + 1'b1) >= {1'b0, lim_q}) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wait_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wait_q  <= wait_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      col_q   <= '0;
      coln_q  <= 1'b1;
      page_q  <= '0;
      pagen_q <= 1'b1;
      big_q   <= 1'b0;
      hd_q    <= 1'b0;
      lim_q   <= '0;
    end else if (accept) begin
      op_q    <= req_opcode;
      col_q   <= req_col;
      coln_q  <= req_col_none;
      page_q  <= req_page;
      pagen_q <= req_page_none;
      big_q   <= big_page;
      hd_q    <= high_density;
      lim_q   <= settle_cycles;
    end
  end

  assign nand_cle = sending && cur_cmd;
  assign nand_ale = sending && !cur_cmd;
  assign nand_io  = sending ? cur_byte : 8'h00;
  assign done     = done_q;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_we_n && !nand_cle && !nand_ale)); // R1
  AST_IO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_io) && $stable(nand_cle))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9
endmodule

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;
  localparam int S = 2, P = 3, H = 2, T = S + P + H;

  logic        clk, rst_n, req_valid, req_ready, req_col_none, req_page_none;
  logic        big_page, high_density, nand_cle, nand_ale, nand_we_n, done;
  logic [7:0]  req_opcode, nand_io;
  logic [9:0]  req_col;
  logic [19:0] req_page;
  logic [15:0] settle_cycles;

  nand_cmd_seq #(.SETUP_CLKS(S), .PULSE_CLKS(P), .HOLD_CLKS(H)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_col(req_col), .req_col_none(req_col_none),
    .req_page(req_page), .req_page_none(req_page_none), .big_page(big_page),
    .high_density(high_density), .settle_cycles(settle_cycles),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_io(nand_io), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit c, input logic [7:0] b, input string tag);
    exp_q.push_back({c, !c, b});
    tag_q.push_back(tag);
  endtask

  // Monitor: pops one expected byte at each falling WE# edge.
  logic prev_we = 1'b1;
  int   low_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n && prev_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected bus byte", {nand_cle, nand_ale, nand_io}, 0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({nand_cle, nand_ale, nand_io} == e, t, "cle/ale/byte",
                {nand_cle, nand_ale, nand_io}, e);
        end
      end
      if (!nand_we_n) low_run++;
      if (nand_we_n && !prev_we) begin
        check(low_run == P, "R7", "WE# low width", low_run, P);
        low_run = 0;
      end
      prev_we = nand_we_n;
    end
  end

  task automatic run_req(input logic [7:0] op, input logic [9:0] col, input bit cn,
                         input logic [19:0] pg, input bit pn, input bit big,
                         input bit hd, input logic [15:0] st, input bit poke);
    int n, lat, exp_lat, c;
    n = 0;
    c = cn ? 0 : int'(col);
    if (op != 8'h80) begin
      push(1, op, "R2"); n++;
    end else if (big) begin
      if (c < 256)      begin push(1, 8'h00, "R3"); end
      else if (c < 512) begin push(1, 8'h01, "R3"); c -= 256; end
      else              begin push(1, 8'h50, "R3"); c -= 512; end
      push(1, 8'h80, "R3"); n += 2;
    end else if (c >= 256) begin
      push(1, 8'hFF, "R4"); push(1, 8'h50, "R4"); push(1, 8'h80, "R4");
      c -= 256; n += 3;
    end else begin
      push(1, 8'h00, "R4"); push(1, 8'h80, "R4"); n += 2;
    end
    if (!cn) begin push(0, c[7:0], "R5"); n++; end
    if (!pn) begin
      push(0, pg[7:0], "R5"); push(0, pg[15:8], "R5"); n += 2;
      if (hd) begin push(0, {4'h0, pg[19:16]}, "R6"); n++; end
    end
    exp_lat = n * T + ((st == 0) ? 1 : int'(st));

    req_opcode = op; req_col = col; req_col_none = cn; req_page = pg;
    req_page_none = pn; big_page = big; high_density = hd; settle_cycles = st;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R9", "ready after accept", req_ready, 0);
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 4) begin
        check(!req_ready, "R9", "ready while busy", req_ready, 0);
        req_opcode = 8'h3C; req_valid = 1'b1;
      end
      if (poke && lat == 5) req_valid = 1'b0;
      if (done || lat > 20000) break;
    end
    check(lat == exp_lat, "R8", "done latency", lat, exp_lat);
    check(exp_q.size() == 0, "R5", "bytes left unsent", exp_q.size(), 0);
    check(!nand_cle && !nand_ale, "R1", "latch enables at done",
          {nand_cle, nand_ale}, 0);
    check(req_ready, "R9", "ready at done", req_ready, 1);
    exp_q.delete(); tag_q.delete();
    @(negedge clk);
    check(!done, "R8", "done width", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual no finish expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_opcode = '0; req_col = '0;
    req_col_none = 1'b1; req_page = '0; req_page_none = 1'b1;
    big_page = 1'b1; high_density = 1'b0; settle_cycles = 16'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && nand_we_n && !done, "R9", "reset idle state",
          {req_ready, nand_we_n, done}, 3'b110);
    check(!nand_cle && !nand_ale, "R1", "reset latch enables", {nand_cle, nand_ale}, 0);

    run_req(8'h00, 10'd5,   0, 20'h01234, 0, 1, 0, 16'd4, 0);    // R2 R5
    run_req(8'h90, 10'd0,   1, 20'h0,     1, 1, 0, 16'd2, 0);    // R5 no address
    run_req(8'h70, 10'd77,  0, 20'h0,     1, 1, 0, 16'd1, 0);    // R5 column only
    run_req(8'h80, 10'd100, 0, 20'h00042, 0, 1, 0, 16'd3, 0);    // R3 first half
    run_req(8'h80, 10'd300, 0, 20'h00101, 0, 1, 0, 16'd3, 0);    // R3 second half
    run_req(8'h80, 10'd515, 0, 20'h00202, 0, 1, 0, 16'd3, 0);    // R3 spare area
    run_req(8'h80, 10'd260, 0, 20'h00303, 0, 0, 0, 16'd3, 0);    // R4 reset path
    run_req(8'h80, 10'd10,  0, 20'h00404, 0, 0, 0, 16'd3, 0);    // R4 low column
    run_req(8'h60, 10'd0,   1, 20'hABCDE, 0, 1, 1, 16'd5, 0);    // R6
    run_req(8'h80, 10'd0,   1, 20'h5A5A5, 0, 1, 1, 16'd0, 0);    // R3 R6 settle 0
    run_req(8'h30, 10'd9,   0, 20'h00777, 0, 1, 0, 16'd6, 1);    // R9 busy poke
    run_req(8'h10, 10'd0,   1, 20'h00010, 0, 1, 0, 16'd3750, 0); // R8 nominal settle

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule